// File: doc/BRIEF.md
# LPC I/O Address Match Decoder

This block keeps a 16-bit host base address for one LPC channel and checks every host I/O address against it. It raises a one-hot select when the address falls in one of two windows. The first window covers a data-in register, a data-out register and a status register. The second window covers sixteen bidirectional data registers. The frame decoder that extracts the I/O address, and the data registers themselves, sit outside the block. This block supplies only the match, the one-hot select and the index of the bidirectional register.

Local software loads the base as two byte-wide halves. It reads either half back through the same small register port. Bit 0 of the low byte enables the bidirectional window. Bit 2 of the low byte is reserved: it holds whatever is written and plays no part in decoding. While the channel enable is high, the base is locked and writes to it are dropped.

The two windows use different compare rules against the same base. The data/status window forces base bit 0 to zero and ignores address bit 2. The bidirectional window inverts base bit 4 and ignores address bits 3 to 0. Each address strobe produces a registered result one clock later.

Top module: `lpc_io_decode`

## Requirements
- R1: After reset both base bytes read 0, and hit_o, sel_o and bidir_idx_o are 0.
- R2: With chan_en_i = 0, a write with reg_sel_i = 1 loads the high byte (base bits 15..8), and a write with reg_sel_i = 0 loads the low byte (bits 7..0). Each write leaves the other byte unchanged. reg_rdata_o shows the byte picked by reg_sel_i. All eight bits read back as written, including reserved low-byte bit 2.
- R3: While chan_en_i = 1, register writes are ignored and both bytes keep their value.
- R4: While chan_en_i = 0, no address strobe produces a hit: sel_o = 0, hit_o = 0 and bidir_idx_o = 0.
- R5: The data/status window matches when all of the following hold: addr[15:3] = base[15:3], addr[1] = base[1] and addr[0] = 0. Address bit 2 and base bits 2 and 0 are ignored.
- R6: On a data/status match, addr[2] = 0 with io_write_i = 1 sets sel_o = 4'b0001 (data-in). addr[2] = 0 with io_write_i = 0 sets sel_o = 4'b0010 (data-out). addr[2] = 1 sets sel_o = 4'b0100 (status).
- R7: The bidirectional window matches when base bit 0 = 1, addr[15:5] = base[15:5] and addr[4] = ~base[4]. On a match, sel_o = 4'b1000 and bidir_idx_o = addr[3:0].
- R8: With base bit 0 = 0, no address selects a bidirectional register, and the data/status window is unaffected.
- R9: hit_o, sel_o and bidir_idx_o are updated on the clock edge that samples io_valid_i = 1, using that cycle's inputs. After an edge that samples io_valid_i = 0 they are all 0. sel_o is one-hot or zero, and hit_o = |sel_o. When both windows match, the data/status window wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable; also locks the base |
| reg_wr_i | input | 1 | Base byte write strobe |
| reg_sel_i | input | 1 | Byte select: 1 high, 0 low |
| reg_wdata_i | input | 8 | Base byte write data |
| reg_rdata_o | output | 8 | Selected base byte readback |
| io_valid_i | input | 1 | Host I/O address strobe |
| io_write_i | input | 1 | Host cycle direction: 1 write, 0 read |
| io_addr_i | input | 16 | Host I/O address |
| hit_o | output | 1 | Address matched a window |
| sel_o | output | 4 | One-hot select: data-in, data-out, status, bidirectional |
| bidir_idx_o | output | 4 | Bidirectional register index |

## Verification
The decode result is due on the edge that samples the strobe. The bench therefore drives each strobe at a falling edge and compares hit_o, sel_o and bidir_idx_o at the next falling edge. It compares them against a model built from the base value in force when the strobe was driven. Register readback is combinational. It is compared at the falling edge after the write edge, so a write refused under the lock shows up directly as an unchanged byte. Strobe-free cycles are mixed into the random stream, which checks that the outputs return to zero one edge after the strobe drops.

// File: rtl/lpc_dec_pkg.sv
package lpc_dec_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_BIDIR = 16;
  localparam int unsigned IDX_W     = $clog2(NUM_BIDIR);
  localparam int unsigned SEL_W     = 4;

  // one-hot select bit positions
  typedef enum logic [1:0] {
    SEL_DIN  = 2'd0,
    SEL_DOUT = 2'd1,
    SEL_STAT = 2'd2,
    SEL_BIDI = 2'd3
  } sel_pos_e;

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
  // data/status window: address bit 2 is don't-care, base bit 0 forced low
  localparam logic [ADDR_W-1:0] DS_CARE   = ALL_ONES & ~(ADDR_W'(1) << 2);
  localparam logic [ADDR_W-1:0] DS_INV    = '0;
  localparam logic [ADDR_W-1:0] DS_FORCE0 = ADDR_W'(1);
  // bidirectional window: index bits don't-care, base bit above them inverted
  localparam logic [ADDR_W-1:0] BD_CARE   = ALL_ONES << IDX_W;
  localparam logic [ADDR_W-1:0] BD_INV    = ADDR_W'(1) << IDX_W;
  localparam logic [ADDR_W-1:0] BD_FORCE0 = '0;
endpackage

// File: rtl/lpc_base_reg.sv
module lpc_base_reg
  import lpc_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              wr_i,
  input  logic              sel_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int unsigned NBYTES = ADDR_W / BYTE_W;

  logic [ADDR_W-1:0] base_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic hit_byte;
    assign hit_byte = wr_i && !lock_i && (sel_hi_i == (b != 0));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       base_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (hit_byte) base_q[b*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  assign rdata_o = sel_hi_i ? base_q[ADDR_W-1 -: BYTE_W] : base_q[BYTE_W-1:0];
  assign base_o  = base_q;
endmodule

// File: rtl/lpc_win_match.sv
module lpc_win_match
  import lpc_dec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CARE   = '1,
  parameter logic [ADDR_W-1:0] INV    = '0,
  parameter logic [ADDR_W-1:0] FORCE0 = '0
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o
);
  logic [ADDR_W-1:0] ref_addr;
  assign ref_addr = (base_i ^ INV) & ~FORCE0;
  assign match_o  = en_i && (((addr_i ^ ref_addr) & CARE) == '0);
endmodule

// File: rtl/lpc_io_decode.sv
module lpc_io_decode
  import lpc_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_en_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              io_valid_i,
  input  logic              io_write_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [IDX_W-1:0]  bidir_idx_o
);
  logic [ADDR_W-1:0] base;
  logic              ds_match, bd_match;
  logic [SEL_W-1:0]  sel_d, sel_q;
  logic [IDX_W-1:0]  idx_d, idx_q;

  lpc_base_reg i_base (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (chan_en_i),
    .wr_i     (reg_wr_i),
    .sel_hi_i (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .base_o   (base)
  );

  lpc_win_match #(.CARE(DS_CARE), .INV(DS_INV), .FORCE0(DS_FORCE0)) i_ds_match (
    .en_i    (chan_en_i),
    .base_i  (base),
    .addr_i  (io_addr_i),
    .match_o (ds_match)
  );

  // bit 0 of the base doubles as the bidirectional window enable
  lpc_win_match #(.CARE(BD_CARE), .INV(BD_INV), .FORCE0(BD_FORCE0)) i_bd_match (
    .en_i    (chan_en_i && base[0]),
    .base_i  (base),
    .addr_i  (io_addr_i),
    .match_o (bd_match)
  );

  always_comb begin
    sel_d = '0;
    idx_d = '0;
    if (io_valid_i) begin
      if (ds_match) begin
        if (io_addr_i[2])    sel_d[SEL_STAT] = 1'b1;
        else if (io_write_i) sel_d[SEL_DIN]  = 1'b1;
        else                 sel_d[SEL_DOUT] = 1'b1;
      end else if (bd_match) begin
        sel_d[SEL_BIDI] = 1'b1;
        idx_d           = io_addr_i[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      idx_q <= '0;
      hit_o <= 1'b0;
    end else begin
      sel_q <= sel_d;
      idx_q <= idx_d;
      hit_o <= ds_match || bd_match ? io_valid_i : 1'b0;
    end
  end

  assign sel_o       = sel_q;
  assign bidir_idx_o = idx_q;
endmodule

// File: rtl/lpc_io_decode_chk.sv
module lpc_io_decode_chk
  import lpc_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chan_en_i,
  input logic              reg_wr_i,
  input logic              io_valid_i,
  input logic [ADDR_W-1:0] base,
  input logic              hit_o,
  input logic [SEL_W-1:0]  sel_o,
  input logic [IDX_W-1:0]  bidir_idx_o
);
  // R9
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  // R9
  hit_sel_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (sel_o != '0));
  // R9
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_valid_i |=> (sel_o == '0) && (bidir_idx_o == '0));
  // R4
  no_hit_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> !hit_o);
  // R3
  base_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_i && reg_wr_i |=> $stable(base));
  // R8
  bidir_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base[0] && $stable(base) |=> !sel_o[SEL_BIDI]);
endmodule

bind lpc_io_decode lpc_io_decode_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_en_i   (chan_en_i),
  .reg_wr_i    (reg_wr_i),
  .io_valid_i  (io_valid_i),
  .base        (base),
  .hit_o       (hit_o),
  .sel_o       (sel_o),
  .bidir_idx_o (bidir_idx_o)
);

// File: tb/test_lpc_io_decode.sv
module test_lpc_io_decode;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic        hit;
  logic [3:0]  sel;
  logic [3:0]  idx;

  int unsigned n_chk = 0, n_bad = 0;
  logic [15:0] m_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_io_decode i_lpc_io_decode (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .io_valid_i(io_valid), .io_write_i(io_write),
    .io_addr_i(io_addr), .hit_o(hit), .sel_o(sel), .bidir_idx_o(idx)
  );

  function automatic logic [3:0] exp_sel(logic [15:0] b, logic en, logic v,
                                         logic w, logic [15:0] a);
    logic ds, bd;
    ds = (a[15:3] == b[15:3]) && (a[1] == b[1]) && !a[0];
    bd = b[0] && (a[15:5] == b[15:5]) && (a[4] == !b[4]);
    if (!en || !v) return 4'b0000;
    if (ds) return a[2] ? 4'b0100 : (w ? 4'b0001 : 4'b0010);
    if (bd) return 4'b1000;
    return 4'b0000;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic hi, logic [7:0] d);
    reg_wr = 1'b1; reg_sel = hi; reg_wdata = d;
    if (!chan_en) begin
      if (hi) m_base[15:8] = d; else m_base[7:0] = d;
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_chk(string req);
    reg_sel = 1'b1; #1; check(req, {8'h0, reg_rdata}, {8'h0, m_base[15:8]});
    reg_sel = 1'b0; #1; check(req, {8'h0, reg_rdata}, {8'h0, m_base[7:0]});
  endtask

  task automatic io(string req, logic v, logic w, logic [15:0] a);
    logic [3:0] es;
    io_valid = v; io_write = w; io_addr = a;
    es = exp_sel(m_base, chan_en, v, w, a);
    @(negedge clk);
    check(req, {11'h0, hit, sel}, {11'h0, |es, es});
    check(req, {12'h0, idx}, {12'h0, es[3] ? a[3:0] : 4'h0});
    io_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'h1f2e3d4c));
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", {11'h0, hit, sel}, 16'h0);
    check("R1", {12'h0, idx}, 16'h0);
    read_chk("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 byte loads, reserved bit 2 held
    reg_write(1'b1, 8'h0C);
    read_chk("R2");
    reg_write(1'b0, 8'hA7);
    read_chk("R2");

    // R4 disabled: no hit
    io("R4", 1'b1, 1'b1, 16'h0CA2);
    io("R4", 1'b1, 1'b0, 16'h0CB5);

    chan_en = 1'b1;
    // R3 locked writes ignored
    reg_write(1'b1, 8'hFF);
    reg_write(1'b0, 8'h00);
    read_chk("R3");

    // R5 R6 data/status window
    io("R6", 1'b1, 1'b1, 16'h0CA2);
    io("R6", 1'b1, 1'b0, 16'h0CA2);
    io("R6", 1'b1, 1'b0, 16'h0CA6);
    io("R5", 1'b1, 1'b1, 16'h0CA3);
    io("R5", 1'b1, 1'b1, 16'h0CA0);
    io("R5", 1'b1, 1'b1, 16'h0CAA);
    // R7 bidirectional window
    io("R7", 1'b1, 1'b0, 16'h0CB5);
    io("R7", 1'b1, 1'b1, 16'h0CBF);
    io("R7", 1'b1, 1'b1, 16'h0CAF);
    // R9 strobe low clears
    io("R9", 1'b0, 1'b1, 16'h0CA2);

    // R8 bidirectional enable off
    chan_en = 1'b0;
    reg_write(1'b0, 8'hA6);
    chan_en = 1'b1;
    io("R8", 1'b1, 1'b0, 16'h0CB5);
    io("R8", 1'b1, 1'b0, 16'h0CA6);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 19) == 0) begin
        chan_en = 1'b0;
        reg_write(1'b1, 8'($urandom));
        reg_write(1'b0, 8'($urandom));
        read_chk("R2");
        chan_en = 1'b1;
      end
      if ($urandom_range(0, 29) == 0) begin
        reg_write(1'($urandom), 8'($urandom));
        read_chk("R3");
      end
      a = ($urandom_range(0, 3) == 0) ? 16'($urandom)
                                      : {m_base[15:5], 5'($urandom)};
      chan_en = ($urandom_range(0, 9) != 0);
      io("R9", ($urandom_range(0, 4) != 0), 1'($urandom), a);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule